// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the receive-side status word of a multi-channel synchronous serial audio port. It watches event pulses from the receive shifter: a detected frame sync, a strobe for each received bit, and the pulse that moves the shift registers into the receive data registers. From these it keeps a frame-sync flag, an overrun flag and three general-purpose input flags. The input flags come from three receive-side pins that carry no clock or sync when the port runs synchronously. The result is a 24-bit status word. The block also raises an interrupt request when an overrun is pending and its exception enable is set.

A pin value is taken on the first bit strobe after a frame sync. It becomes visible in the status word only at the next transfer pulse. Software clears an overrun in two steps. First it reads the status word while the overrun flag is set. Then it reads every receive data register that was enabled at that moment, in any order. A fresh overrun during this sequence means every one of those registers must be read again.

Top module: `rx_status_flags`

## Requirements
- R1: Only status bits 0, 1, 2 (input flags), 6 (frame sync) and 7 (overrun) can be nonzero. Every other bit of the 24-bit word always reads zero.
- R2: Each input flag is gated, and a gated flag reads zero while its stored value is kept. Bit 0 (receive clock pin) needs `syn_mode`=1 and `clk_pin_is_out`=0. Bit 2 (high-frequency clock pin) needs `syn_mode`=1 and `hck_pin_is_out`=0. Bit 1 (frame sync pin) needs `syn_mode`=1, `fs_pin_is_out`=0 and `fs_alt_en`=0.
- R3: The pin values are taken on the first `bit_strobe` after a `frame_sync` pulse. Further strobes in the same frame do not change the captured values.
- R4: The visible input flags change only on an `xfer` pulse, which copies the last captured values into them.
- R5: In network mode (`net_mode`=1), bit 6 is set at `xfer` if a `frame_sync` pulse came during that word. It is cleared at `xfer` if no frame sync came.
- R6: In normal mode, bit 6 reads one whenever any `rx_en` bit is set. With no receiver enabled, bit 6 reads zero in both modes.
- R7: Bit 7 (overrun) sets on an `xfer` pulse while `rdf`=1 and at least one `rx_en` bit is set. An `xfer` with no receiver enabled leaves it clear.
- R8: Overrun clears only after a `stat_rd` that sees it set, followed by `data_rd` pulses covering every receiver enabled at that status read. Data reads without a prior qualifying status read do not clear it.
- R9: A new overrun during a clear sequence keeps the flag set. It re-arms the pending-read mask, so every enabled data register must be read again.
- R10: `ovr_irq` is high exactly when overrun is set and `exc_ie`=1.
- R11: Both `rst_n` low and a `sync_clr` pulse clear the input flags, the frame-sync record and the overrun state.
- R12: The pins pass through a two-stage synchronizer. A pin change made one clock before the capturing strobe is not captured. A change made two or more clocks before it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr | input | 1 | Synchronous clear of all flags (software, block or stop reset) |
| syn_mode | input | 1 | Synchronous mode; required for any input flag |
| net_mode | input | 1 | Network mode (1) or normal mode (0) |
| clk_pin_is_out | input | 1 | Receive clock pin driven as output |
| fs_pin_is_out | input | 1 | Receive frame sync pin driven as output |
| hck_pin_is_out | input | 1 | High-frequency receive clock pin driven as output |
| fs_alt_en | input | 1 | Alternate frame-sync-pin use; blocks flag bit 1 |
| pin_clk | input | 1 | Asynchronous receive clock pin level |
| pin_fs | input | 1 | Asynchronous receive frame sync pin level |
| pin_hck | input | 1 | Asynchronous high-frequency clock pin level |
| frame_sync | input | 1 | Frame sync detected pulse |
| bit_strobe | input | 1 | One pulse per received data bit |
| xfer | input | 1 | Shift-to-data-register transfer pulse |
| rdf | input | 1 | Receive data registers already full |
| rx_en | input | NUM_RX | Receiver enables |
| exc_ie | input | 1 | Overrun exception interrupt enable |
| stat_rd | input | 1 | Status word read strobe |
| data_rd | input | NUM_RX | Per-receiver data register read strobes |
| status | output | 24 | Status word |
| ovr_irq | output | 1 | Overrun exception interrupt request |

## Verification
The bench builds the block with NUM_RX=2 and the default two synchronizer stages. With two receivers it can leave one enabled and one disabled at the status read. It can also read the data registers in either order, and it can start a new overrun after only part of the pending mask has been read. The default stage count makes the one-clock-too-late pin change observable. Both normal and network modes are driven so that each way bit 6 is formed is exercised.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
    localparam int STAT_W   = 24;
    localparam int NUM_PINS = 3;
    localparam int BIT_IF0  = 0;
    localparam int BIT_IF1  = 1;
    localparam int BIT_IF2  = 2;
    localparam int BIT_RFS  = 6;
    localparam int BIT_ROE  = 7;
    localparam logic [STAT_W-1:0] LIVE_MASK =
        STAT_W'((1 << BIT_IF0) | (1 << BIT_IF1) | (1 << BIT_IF2) |
                (1 << BIT_RFS) | (1 << BIT_ROE));

    typedef struct packed {
        logic fs_seen;
        logic rfs;
    } frame_state_t;
endpackage

// File: rtl/rxsf_pin_sync.sv
module rxsf_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rxsf_capture.sv
module rxsf_capture #(
    parameter int NPIN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            frame_sync,
    input  logic            bit_strobe,
    input  logic            xfer,
    input  logic [NPIN-1:0] pins_s,
    output logic [NPIN-1:0] flags_raw
);
    typedef struct packed {
        logic            armed;
        logic [NPIN-1:0] held;
        logic [NPIN-1:0] shown;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a frame sync arms the capture; the first later strobe takes the pins
        if (frame_sync) begin
            st_d.armed = 1'b1;
        end else if (bit_strobe && st_q.armed) begin
            st_d.held  = pins_s;
            st_d.armed = 1'b0;
        end
        // visible copy moves only with the data register transfer
        if (xfer) begin
            st_d.shown = st_q.held;
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_raw = st_q.shown;
endmodule

// File: rtl/rxsf_frame_flag.sv
module rxsf_frame_flag
    import rxsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic frame_sync,
    input  logic xfer,
    output logic rfs_raw
);
    frame_state_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (xfer) begin
            // a sync arriving with the transfer belongs to the next word
            fr_d.rfs     = fr_q.fs_seen;
            fr_d.fs_seen = frame_sync;
        end else if (frame_sync) begin
            fr_d.fs_seen = 1'b1;
        end
        if (clr) begin
            fr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign rfs_raw = fr_q.rfs;
endmodule

// File: rtl/rxsf_overrun.sv
module rxsf_overrun #(
    parameter int NUM_RX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              xfer,
    input  logic              rdf,
    input  logic [NUM_RX-1:0] rx_en,
    input  logic              stat_rd,
    input  logic [NUM_RX-1:0] data_rd,
    output logic              ovr
);
    typedef struct packed {
        logic              ovr;
        logic              armed;
        logic [NUM_RX-1:0] pend;
    } ovr_state_t;

    ovr_state_t ov_d, ov_q;
    logic              set_evt;
    logic              arm_evt;
    logic [NUM_RX-1:0] pend_left;

    assign set_evt   = xfer && rdf && (|rx_en);
    assign arm_evt   = stat_rd && ov_q.ovr;
    assign pend_left = ov_q.pend & ~data_rd;

    always_comb begin
        ov_d = ov_q;
        // progress of an armed sequence: each data read retires one receiver
        if (ov_q.armed) begin
            ov_d.pend = pend_left;
            if (pend_left == '0) begin
                ov_d.ovr   = 1'b0;
                ov_d.armed = 1'b0;
            end
        end
        // qualifying status read (re)arms the mask from the enabled receivers
        if (arm_evt) begin
            ov_d.armed = 1'b1;
            ov_d.pend  = rx_en;
            if (rx_en == '0) begin
                ov_d.ovr   = 1'b0;
                ov_d.armed = 1'b0;
            end
        end
        // a new overrun wins over any clear and restarts the pending mask
        if (set_evt) begin
            ov_d.ovr = 1'b1;
            if (ov_q.armed || arm_evt) begin
                ov_d.armed = 1'b1;
                ov_d.pend  = rx_en;
            end
        end
        if (clr) begin
            ov_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ov_q <= '0;
        else        ov_q <= ov_d;
    end

    assign ovr = ov_q.ovr;
endmodule

// File: rtl/rx_status_flags.sv
module rx_status_flags
    import rxsf_pkg::*;
#(
    parameter int NUM_RX      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              syn_mode,
    input  logic              net_mode,
    input  logic              clk_pin_is_out,
    input  logic              fs_pin_is_out,
    input  logic              hck_pin_is_out,
    input  logic              fs_alt_en,
    input  logic              pin_clk,
    input  logic              pin_fs,
    input  logic              pin_hck,
    input  logic              frame_sync,
    input  logic              bit_strobe,
    input  logic              xfer,
    input  logic              rdf,
    input  logic [NUM_RX-1:0] rx_en,
    input  logic              exc_ie,
    input  logic              stat_rd,
    input  logic [NUM_RX-1:0] data_rd,
    output logic [STAT_W-1:0] status,
    output logic              ovr_irq
);
    logic [NUM_PINS-1:0] pins_s;
    logic [NUM_PINS-1:0] flags_raw;
    logic [NUM_PINS-1:0] pin_en;
    logic                rfs_raw;
    logic                ovr;

    rxsf_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({pin_hck, pin_fs, pin_clk}),
        .sync_out (pins_s)
    );

    rxsf_capture #(.NPIN(NUM_PINS)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sync_clr),
        .frame_sync (frame_sync),
        .bit_strobe (bit_strobe),
        .xfer       (xfer),
        .pins_s     (pins_s),
        .flags_raw  (flags_raw)
    );

    rxsf_frame_flag u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sync_clr),
        .frame_sync (frame_sync),
        .xfer       (xfer),
        .rfs_raw    (rfs_raw)
    );

    rxsf_overrun #(.NUM_RX(NUM_RX)) u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_clr),
        .xfer    (xfer),
        .rdf     (rdf),
        .rx_en   (rx_en),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .ovr     (ovr)
    );

    // a pin reports only when it is an input and the port runs synchronously
    assign pin_en[BIT_IF0] = syn_mode && !clk_pin_is_out;
    assign pin_en[BIT_IF1] = syn_mode && !fs_pin_is_out && !fs_alt_en;
    assign pin_en[BIT_IF2] = syn_mode && !hck_pin_is_out;

    always_comb begin
        status = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            status[BIT_IF0 + i] = flags_raw[i] && pin_en[i];
        end
        status[BIT_RFS] = (|rx_en) && (net_mode ? rfs_raw : 1'b1);
        status[BIT_ROE] = ovr;
    end

    assign ovr_irq = ovr && exc_ie;
endmodule

// File: rtl/rxsf_checker.sv
module rxsf_checker #(
    parameter int NUM_RX = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_clr,
    input logic              syn_mode,
    input logic              net_mode,
    input logic [4:0]        mode_vec,
    input logic              xfer,
    input logic              rdf,
    input logic [NUM_RX-1:0] rx_en,
    input logic              stat_rd,
    input logic [NUM_RX-1:0] data_rd,
    input logic [23:0]       status,
    input logic              ovr_irq
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~rxsf_pkg::LIVE_MASK) == '0); // R1

    AST_IF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_mode |-> status[2:0] == 3'b000); // R2

    AST_IF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !sync_clr) |=> (!$stable(mode_vec) || $stable(status[2:0]))); // R4

    AST_RFS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!net_mode && (|rx_en)) |-> status[6]); // R6

    AST_RFS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en == '0) |-> !status[6]); // R6

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && rdf && (|rx_en) && !sync_clr) |=> status[7]); // R7

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(status[7]) && !$past(sync_clr)) |->
            ($past(|data_rd) || ($past(stat_rd) && $past(rx_en) == '0))); // R8

    AST_IRQ_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq |-> status[7]); // R10

    AST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (status[7] == 1'b0 && status[2:0] == 3'b000)); // R11
endmodule

bind rx_status_flags rxsf_checker #(.NUM_RX(NUM_RX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_clr (sync_clr),
    .syn_mode (syn_mode),
    .net_mode (net_mode),
    .mode_vec ({syn_mode, clk_pin_is_out, fs_pin_is_out, hck_pin_is_out, fs_alt_en}),
    .xfer     (xfer),
    .rdf      (rdf),
    .rx_en    (rx_en),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .status   (status),
    .ovr_irq  (ovr_irq)
);

// File: tb/sim_rx_status_flags.sv
`timescale 1ns/1ps
module sim_rx_status_flags;
    localparam int NRX = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_clr = 0, syn_mode = 1, net_mode = 0;
    logic clk_pin_is_out = 0, fs_pin_is_out = 0, hck_pin_is_out = 0, fs_alt_en = 0;
    logic pin_clk = 0, pin_fs = 0, pin_hck = 0;
    logic frame_sync = 0, bit_strobe = 0, xfer = 0, rdf = 0, exc_ie = 0, stat_rd = 0;
    logic [NRX-1:0] rx_en = '0;
    logic [NRX-1:0] data_rd = '0;
    logic [23:0] status;
    logic        ovr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic [23:0] st;
        logic        irq;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    rx_status_flags #(.NUM_RX(NRX), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .syn_mode(syn_mode),
        .net_mode(net_mode), .clk_pin_is_out(clk_pin_is_out),
        .fs_pin_is_out(fs_pin_is_out), .hck_pin_is_out(hck_pin_is_out),
        .fs_alt_en(fs_alt_en), .pin_clk(pin_clk), .pin_fs(pin_fs), .pin_hck(pin_hck),
        .frame_sync(frame_sync), .bit_strobe(bit_strobe), .xfer(xfer), .rdf(rdf),
        .rx_en(rx_en), .exc_ie(exc_ie), .stat_rd(stat_rd), .data_rd(data_rd),
        .status(status), .ovr_irq(ovr_irq)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (status !== e.st || ovr_irq !== e.irq) begin
                fails++;
                $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                         e.tag, status, ovr_irq, e.st, e.irq);
            end
        end
    end

    task automatic expect_out(input string tag, input logic [23:0] st, input logic irq);
        exp_t e;
        e.tag = tag; e.st = st; e.irq = irq;
        sb_q.push_back(e);
    endtask

    task automatic nx();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) nx();
    endtask

    task automatic do_fs();      nx(); frame_sync = 1; nx(); frame_sync = 0; endtask
    task automatic do_strobe();  nx(); bit_strobe = 1; nx(); bit_strobe = 0; endtask
    task automatic do_xfer();    nx(); xfer = 1;       nx(); xfer = 0;       endtask
    task automatic do_ovr();     nx(); rdf = 1; xfer = 1; nx(); rdf = 0; xfer = 0; endtask
    task automatic do_stat();    nx(); stat_rd = 1;    nx(); stat_rd = 0;    endtask
    task automatic do_clr();     nx(); sync_clr = 1;   nx(); sync_clr = 0;   endtask
    task automatic do_data(input logic [NRX-1:0] m);
        nx(); data_rd = m; nx(); data_rd = '0;
    endtask
    task automatic set_pins(input logic [2:0] p);
        nx(); {pin_hck, pin_fs, pin_clk} = p;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, status=%h expected sequence end", status);
            finish_up();
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        nx();
        expect_out("R11 reset state", 24'h000000, 1'b0);

        nx(); rx_en = 2'b11;
        expect_out("R6 normal mode reads one", 24'h000040, 1'b0);

        // first capture, all pins high
        set_pins(3'b111); idle(3);
        do_fs(); do_strobe();
        expect_out("R4 captured but not shown", 24'h000040, 1'b0);
        do_xfer();
        expect_out("R1 R3 flags shown at transfer", 24'h000047, 1'b0);

        // enable gating
        nx(); fs_alt_en = 1;
        expect_out("R2 fs alt use gates bit1", 24'h000045, 1'b0);
        nx(); fs_alt_en = 0; fs_pin_is_out = 1;
        expect_out("R2 fs pin output gates bit1", 24'h000045, 1'b0);
        nx(); fs_pin_is_out = 0; clk_pin_is_out = 1;
        expect_out("R2 clk pin output gates bit0", 24'h000046, 1'b0);
        nx(); clk_pin_is_out = 0; hck_pin_is_out = 1;
        expect_out("R2 hck pin output gates bit2", 24'h000043, 1'b0);
        nx(); hck_pin_is_out = 0; syn_mode = 0;
        expect_out("R2 async mode gates all", 24'h000040, 1'b0);
        nx(); syn_mode = 1;
        expect_out("R2 stored value kept", 24'h000047, 1'b0);

        // only the first strobe after sync counts
        set_pins(3'b101); idle(3);
        do_fs(); do_strobe();
        set_pins(3'b010); idle(3);
        do_strobe(); do_xfer();
        expect_out("R3 first strobe only", 24'h000045, 1'b0);

        // synchronizer latency
        set_pins(3'b000); idle(3);
        do_fs();
        set_pins(3'b111);
        do_strobe(); do_xfer();
        expect_out("R12 late change not captured", 24'h000040, 1'b0);
        idle(3);
        do_fs(); do_strobe(); do_xfer();
        expect_out("R12 settled change captured", 24'h000047, 1'b0);

        // network mode frame sync flag
        nx(); net_mode = 1;
        do_fs(); do_strobe(); do_xfer();
        expect_out("R5 word with sync", 24'h000047, 1'b0);
        do_strobe(); do_xfer();
        expect_out("R5 word without sync", 24'h000007, 1'b0);

        nx(); net_mode = 0;
        expect_out("R6 normal mode forces one", 24'h000047, 1'b0);
        nx(); rx_en = 2'b00;
        expect_out("R6 no receiver enabled", 24'h000007, 1'b0);

        // overrun set
        do_ovr();
        expect_out("R7 no overrun without receiver", 24'h000007, 1'b0);
        nx(); rx_en = 2'b11;
        do_ovr();
        expect_out("R7 R10 overrun set, irq masked", 24'h0000C7, 1'b0);
        nx(); exc_ie = 1;
        expect_out("R10 irq raised", 24'h0000C7, 1'b1);

        // clear sequence
        do_data(2'b11);
        expect_out("R8 data reads alone ignored", 24'h0000C7, 1'b1);
        do_stat();
        expect_out("R8 status read alone", 24'h0000C7, 1'b1);
        do_data(2'b01);
        expect_out("R8 partial reads", 24'h0000C7, 1'b1);
        do_data(2'b10);
        expect_out("R8 cleared after all reads", 24'h000047, 1'b0);

        // disabled receiver need not be read
        do_ovr();
        expect_out("R7 overrun again", 24'h0000C7, 1'b1);
        nx(); rx_en = 2'b01;
        do_stat(); do_data(2'b01);
        expect_out("R8 only enabled receivers", 24'h000047, 1'b0);
        nx(); rx_en = 2'b11;

        // new overrun during the sequence
        do_ovr(); do_stat(); do_data(2'b01);
        do_ovr();
        do_data(2'b10);
        expect_out("R9 mask re-armed", 24'h0000C7, 1'b1);
        do_data(2'b01);
        expect_out("R9 cleared after re-read", 24'h000047, 1'b0);

        // synchronous clear
        do_ovr();
        do_clr();
        expect_out("R11 sync clear", 24'h000040, 1'b0);

        idle(3);
        done = 1;
        finish_up();
    end
endmodule